// File: doc/BRIEF.md
# Latched Pin-Change Interrupt Controller

This block monitors a small group of general-purpose input pins and raises a latched, active-low interrupt when any enabled pin changes level. Each pin first passes through a synchroniser. The block keeps a reference copy of the pin levels, called the snapshot, and one sticky change flag per pin. The interrupt output is the enable of an external pull-low driver: logic 1 means the line is released.

A neighbouring serial-bus slave drives the block with single-cycle strobes and one level:
- The acknowledge of the slave address reloads the snapshot, clears the flags and releases the interrupt.
- During a multi-byte read, the acknowledge that opens each new data pair resamples the snapshot and clears the flags.
- A STOP condition, or a bus abort, ends the transaction.
- The read-in-progress level marks the span of a read.

While a read is in progress, a pin change is recorded but does not assert the interrupt. It becomes a pending interrupt that is released at the end of the transaction. The pending interrupt is dropped if a later resample has already captured the changed value. The enable mask is loaded from outside through a load strobe.

Top module: `pin_change_irq`

## Requirements
- R1: After reset the interrupt output is 1 (released), all flags are 0 and the mask enables every pin. The block settles its snapshot from the synchronised pins before it starts detecting changes.
- R2: A level change on an enabled pin outside a read reaches the flags and the interrupt on the third rising clock edge after the change. It is not visible after the second edge.
- R3: An address-acknowledge strobe loads the synchronised pin levels into the snapshot, clears all flags and sets the interrupt output to 1. All three take effect at the next edge.
- R4: Outside a read, any difference between an enabled synchronised pin and the snapshot sets that pin's flag and drives the interrupt output to 0. Flags and interrupt stay set even if the pin returns to its snapshot level.
- R5: A mask-load strobe loads the mask input. Mask bit i set to 1 enables pin i. A change on a disabled pin sets no flag and leaves the interrupt output at 1.
- R6: While read-in-progress is 1, a change sets its flag but leaves the interrupt output at 1.
- R7: At a STOP strobe, if a change has been seen since the last resample, the interrupt output goes to 0 at the next edge.
- R8: A pair-acknowledge strobe resamples the snapshot and clears the flags without touching the interrupt output. A change captured this way does not assert the interrupt at the following STOP.
- R9: A bus-abort strobe neither clears the flags nor releases the interrupt. It releases a pending interrupt in the same way as STOP.
- R10: When a pin change reaches the synchronised level in the same cycle as an address-acknowledge strobe, the new level goes into the snapshot. No flag is set for it and the interrupt output stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | NUM_PINS | Asynchronous input pins |
| maskLoad | input | 1 | Strobe: load maskIn into the enable mask |
| maskIn | input | NUM_PINS | New enable mask, 1 = pin enabled |
| addrAck | input | 1 | Strobe: slave address acknowledged |
| pairAck | input | 1 | Strobe: acknowledge that opens a new read data pair |
| stopSeen | input | 1 | Strobe: bus STOP condition |
| busAbort | input | 1 | Strobe: transaction aborted by bus reset |
| readActive | input | 1 | Level: a read transaction is in progress |
| intN | output | 1 | Pull-low enable; 0 = interrupt asserted |
| snapOut | output | NUM_PINS | Snapshot register for readback |
| flagsOut | output | NUM_PINS | Sticky per-pin change flags for readback |

## Verification
The checker assumes that every event input is a one-cycle pulse and that readActive stays high from the address acknowledge until STOP or abort. It also assumes that a pin holds each level for at least as long as the synchroniser depth, so that snapshot and flag timing are deterministic. The stimulus changes pins only on falling clock edges and leaves at least three cycles between a pin change and the next strobe. The one exception is the deliberate same-cycle case, where the strobe is placed exactly on the edge at which the new level reaches the synchronised stage.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;   // reload snapshot, clear flags
  } ctlStrobes_t;
endpackage

// File: rtl/pin_change_irq_dp.sv
module pin_change_irq_dp
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                maskLoad,
  input  logic [NUM_PINS-1:0] maskIn,
  input  ctlStrobes_t         strobes,
  output logic [NUM_PINS-1:0] pinSync,
  output logic [NUM_PINS-1:0] snapQ,
  output logic [NUM_PINS-1:0] flagsQ,
  output logic                anyDiff
);
  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] maskQ;
  logic [NUM_PINS-1:0] diffVec;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= pinIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinSync = syncQ[SYNC_STAGES-1];
  assign diffVec = (pinSync ^ snapQ) & maskQ;
  assign anyDiff = |diffVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= '1;
    else if (maskLoad) maskQ <= maskIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapQ  <= '0;
      flagsQ <= '0;
    end else if (strobes.capture) begin
      snapQ  <= pinSync;
      flagsQ <= '0;
    end else begin
      flagsQ <= flagsQ | diffVec;
    end
  end
endmodule

// File: rtl/pin_change_irq_ctl.sv
module pin_change_irq_ctl
  import pin_change_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrAck,
  input  logic        pairAck,
  input  logic        stopSeen,
  input  logic        busAbort,
  input  logic        readActive,
  input  logic        anyDiff,
  output ctlStrobes_t strobes,
  output logic        intN
);
  localparam int WARM_LAST = SYNC_STAGES + 1;
  localparam int WARM_W    = $clog2(WARM_LAST + 1);

  logic [WARM_W-1:0] warmCnt;
  logic              warming;
  logic              heldQ;
  logic              diffSeen;
  logic              endEv;

  assign warming         = (warmCnt != WARM_W'(WARM_LAST));
  assign diffSeen        = anyDiff & ~warming;
  assign endEv           = stopSeen | busAbort;
  assign strobes.capture = warming | addrAck | pairAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
      intN    <= 1'b1;
      heldQ   <= 1'b0;
    end else begin
      if (warming) warmCnt <= warmCnt + 1'b1;
      if (addrAck) begin
        intN  <= 1'b1;
        heldQ <= 1'b0;
      end else if (endEv) begin
        if (heldQ | diffSeen) intN <= 1'b0;
        heldQ <= 1'b0;
      end else if (pairAck) begin
        heldQ <= 1'b0;
      end else if (diffSeen) begin
        if (readActive) heldQ <= 1'b1;
        else intN <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_PINS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic                maskLoad,
  input  logic [NUM_PINS-1:0] maskIn,
  input  logic                addrAck,
  input  logic                pairAck,
  input  logic                stopSeen,
  input  logic                busAbort,
  input  logic                readActive,
  output logic                intN,
  output logic [NUM_PINS-1:0] snapOut,
  output logic [NUM_PINS-1:0] flagsOut
);
  ctlStrobes_t         strobes;
  logic                anyDiff;
  logic [NUM_PINS-1:0] pinSync;

  pin_change_irq_dp #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .maskLoad(maskLoad), .maskIn(maskIn),
    .strobes(strobes), .pinSync(pinSync), .snapQ(snapOut), .flagsQ(flagsOut),
    .anyDiff(anyDiff)
  );

  pin_change_irq_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .clk(clk), .rstN(rstN), .addrAck(addrAck), .pairAck(pairAck),
    .stopSeen(stopSeen), .busAbort(busAbort), .readActive(readActive),
    .anyDiff(anyDiff), .strobes(strobes), .intN(intN)
  );
endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                addrAck,
  input logic                pairAck,
  input logic                stopSeen,
  input logic                busAbort,
  input logic                readActive,
  input logic                intN,
  input logic [NUM_PINS-1:0] pinSync,
  input logic [NUM_PINS-1:0] snapOut,
  input logic [NUM_PINS-1:0] flagsOut
);
  // R3
  addr_ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> (intN && flagsOut == '0 && snapOut == $past(pinSync)));

  // R4
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(addrAck || pairAck) |=> ((flagsOut & $past(flagsOut)) == $past(flagsOut)));

  // R6
  read_holds_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readActive && intN && !stopSeen && !busAbort) |=> intN);

  // R7
  int_fall_context_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intN) |-> (!$past(readActive) || $past(stopSeen) || $past(busAbort)));

  // R9
  abort_keeps_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAbort && !intN && !addrAck) |=> !intN);
endmodule

bind pin_change_irq pin_change_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rstN(rstN), .addrAck(addrAck), .pairAck(pairAck),
  .stopSeen(stopSeen), .busAbort(busAbort), .readActive(readActive),
  .intN(intN), .pinSync(pinSync), .snapOut(snapOut), .flagsOut(flagsOut)
);

// File: tb/pin_change_irq_bench.sv
module pin_change_irq_bench;
  localparam int NP = 4;
  localparam int NROWS = 13;
  // {pins[16:13], rd[12], op[11:9], expInt[8], expFlags[7:4], expSnap[3:0]}
  // op: 0 none, 1 addrAck, 2 pairAck, 3 stop, 4 abort
  localparam logic [16:0] VEC [NROWS] = '{
    {4'b0000, 1'b0, 3'd1, 1'b1, 4'b0000, 4'b0000},
    {4'b0001, 1'b0, 3'd0, 1'b0, 4'b0001, 4'b0000},
    {4'b0000, 1'b0, 3'd0, 1'b0, 4'b0001, 4'b0000},
    {4'b0100, 1'b0, 3'd1, 1'b1, 4'b0000, 4'b0100},
    {4'b0100, 1'b1, 3'd0, 1'b1, 4'b0000, 4'b0100},
    {4'b1100, 1'b1, 3'd0, 1'b1, 4'b1000, 4'b0100},
    {4'b1100, 1'b1, 3'd3, 1'b0, 4'b1000, 4'b0100},
    {4'b1100, 1'b1, 3'd1, 1'b1, 4'b0000, 4'b1100},
    {4'b1110, 1'b1, 3'd2, 1'b1, 4'b0000, 4'b1110},
    {4'b1110, 1'b1, 3'd3, 1'b1, 4'b0000, 4'b1110},
    {4'b1111, 1'b1, 3'd4, 1'b0, 4'b0001, 4'b1110},
    {4'b1111, 1'b0, 3'd4, 1'b0, 4'b0001, 4'b1110},
    {4'b1111, 1'b0, 3'd1, 1'b1, 4'b0000, 4'b1111}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic maskLoad = 1'b0;
  logic [NP-1:0] maskIn = '0;
  logic addrAck = 1'b0, pairAck = 1'b0, stopSeen = 1'b0, busAbort = 1'b0;
  logic readActive = 1'b0;
  logic intN;
  logic [NP-1:0] snapOut, flagsOut;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  string rowTag [NROWS];

  always #2.5 clk = ~clk;

  pin_change_irq u_pin_change_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .maskLoad(maskLoad), .maskIn(maskIn),
    .addrAck(addrAck), .pairAck(pairAck), .stopSeen(stopSeen), .busAbort(busAbort),
    .readActive(readActive), .intN(intN), .snapOut(snapOut), .flagsOut(flagsOut)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(logic [2:0] op);
    addrAck  = (op == 3'd1);
    pairAck  = (op == 3'd2);
    stopSeen = (op == 3'd3);
    busAbort = (op == 3'd4);
    step();
    addrAck = 1'b0; pairAck = 1'b0; stopSeen = 1'b0; busAbort = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rowTag = '{"R3", "R4", "R4", "R3", "R6", "R6", "R7", "R3", "R8", "R8", "R9", "R9", "R3"};
    step(2);
    // R1 reset state
    check("R1", "intN in reset", {7'd0, intN}, 8'd1);
    check("R1", "flags in reset", {4'd0, flagsOut}, 8'd0);
    rstN = 1'b1;
    step(5);
    check("R1", "intN after warmup", {7'd0, intN}, 8'd1);
    check("R1", "flags after warmup", {4'd0, flagsOut}, 8'd0);

    for (int r = 0; r < NROWS; r++) begin
      pinIn = VEC[r][16:13];
      readActive = VEC[r][12];
      step(3);
      pulse(VEC[r][11:9]);
      check(rowTag[r], $sformatf("row %0d intN", r), {7'd0, intN}, {7'd0, VEC[r][8]});
      check(rowTag[r], $sformatf("row %0d flags", r), {4'd0, flagsOut}, {4'd0, VEC[r][7:4]});
      check(rowTag[r], $sformatf("row %0d snap", r), {4'd0, snapOut}, {4'd0, VEC[r][3:0]});
    end
    readActive = 1'b0;

    // R2 latency: state snap=1111, flags clear
    pinIn = 4'b1011;
    step(2);
    check("R2", "flags after 2 edges", {4'd0, flagsOut}, 8'd0);
    check("R2", "intN after 2 edges", {7'd0, intN}, 8'd1);
    step();
    check("R2", "flags after 3 edges", {4'd0, flagsOut}, 8'b0100);
    check("R2", "intN after 3 edges", {7'd0, intN}, 8'd0);
    step();
    pulse(3'd1);

    // R5 mask: enable only pin 0
    maskIn = 4'b0001; maskLoad = 1'b1;
    step();
    maskLoad = 1'b0;
    pinIn = 4'b0011;
    step(4);
    check("R5", "masked pin flags", {4'd0, flagsOut}, 8'd0);
    check("R5", "masked pin intN", {7'd0, intN}, 8'd1);
    pinIn = 4'b0010;
    step(3);
    check("R5", "enabled pin flags", {4'd0, flagsOut}, 8'b0001);
    check("R5", "enabled pin intN", {7'd0, intN}, 8'd0);
    maskIn = 4'b1111; maskLoad = 1'b1;
    pulse(3'd1);
    maskLoad = 1'b0;
    check("R5", "snap after reload", {4'd0, snapOut}, 8'b0010);

    // R10 same-cycle change and address acknowledge
    pinIn = 4'b0110;
    step(2);
    pulse(3'd1);
    check("R10", "snap takes new level", {4'd0, snapOut}, 8'b0110);
    check("R10", "no flag", {4'd0, flagsOut}, 8'd0);
    check("R10", "intN released", {7'd0, intN}, 8'd1);
    step(3);
    check("R10", "still no flag", {4'd0, flagsOut}, 8'd0);
    check("R10", "still released", {7'd0, intN}, 8'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule